// File: doc/BRIEF.md
# Split completion tracker

This block follows outstanding read requests from issue to termination. The request side writes one table entry per tag. The entry holds the requester ID, traffic class, attributes, requesting function, the total byte count, the remaining byte count and the low address of the next expected byte. Each incoming completion header is looked up by its tag and checked against the entry. The block then returns one completion descriptor carrying a 4-bit result code and a request-done flag. Depending on the result, the entry is updated, left alone or released.

Each entry has its own down-counting timer, loaded from `tmo_val` when the request is accepted. When the timer runs out, or when a function-level reset names the entry's function, the entry is marked for termination. A small two-state controller then drains the marked entries as synthetic descriptors, lowest tag first. The controller is in `ST_IDLE` when nothing is marked. It moves to `ST_DRAIN` when any entry is marked and returns to `ST_IDLE` once no marks remain. A tag stays busy, and cannot be reissued, until a descriptor with the done flag set has been returned for it.

Top module: `cpl_split_tracker`

## Requirements
- R1: After reset no descriptor is valid and every bit of `tag_busy` is 0.
- R2: A request is accepted only on a tag whose `tag_busy` bit is 0, and that bit then reads 1. A request on a busy tag is ignored and leaves the stored entry unchanged.
- R3: A completion that passes every check gives code 0000. It lowers the remaining count by `cpl_len` and advances the expected low address by `cpl_len` modulo 128. It sets done and frees the tag when `cpl_len` is at least the remaining count.
- R4: A completion with a nonzero `cpl_status` (000 means success) gives code 0010 with done set and frees the tag.
- R5: A byte count above the request's total gives code 0111. Otherwise, a byte count not equal to the remaining count gives code 0011. Both set done and free the tag.
- R6: A completion whose requester ID, traffic class or attributes differ from the live entry gives code 0100 with done clear and leaves the entry unchanged.
- R7: A low address differing from the expected one gives code 0101. The completion is otherwise consumed as in R3, and done is set only when it was the last one.
- R8: A completion whose tag has no live entry gives code 0110 with done clear.
- R9: When several faults apply, the code reports the first of: no live entry, field mismatch, status, byte count above total, byte count mismatch, address.
- R10: An entry whose timer runs out (`tmo_val` cycles after acceptance) is retired with a code 1000 descriptor. That descriptor has done set, carries the tag and function, has all other bits zero, and frees the tag.
- R11: A function-level reset retires every pending entry of that function with R10-style descriptors, lowest tag first, and leaves entries of other functions pending.
- R12: Every completion yields exactly one descriptor in the next cycle, ahead of any pending synthetic one. Descriptor bit positions: code [15:12], done [30], function [55:48], tag [71:64] zero-extended; all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_val | input | TMR_W | Timeout in cycles, loaded per request |
| req_valid | input | 1 | Request issue strobe |
| req_tag | input | TAG_W | Request tag |
| req_rid | input | 16 | Requester ID |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 3 | Attributes |
| req_fn | input | 8 | Requesting function |
| req_bytes | input | 13 | Total bytes requested |
| req_la | input | 7 | Low address of first byte |
| cpl_valid | input | 1 | Completion header strobe |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_rid | input | 16 | Completion requester ID |
| cpl_tc | input | 3 | Completion traffic class |
| cpl_attr | input | 3 | Completion attributes |
| cpl_status | input | 3 | Completion status, 000 = success |
| cpl_bytes | input | 13 | Header byte count (bytes left including this one) |
| cpl_len | input | 13 | Payload bytes in this completion |
| cpl_la | input | 7 | Header low address |
| flr_valid | input | 1 | Function-level reset strobe |
| flr_fn | input | 8 | Function being reset |
| tag_busy | output | NTAG | Per-tag occupied flags |
| dsc_valid | output | 1 | Descriptor valid |
| dsc_word | output | 96 | Descriptor, layout in R12 |

## Verification
The table walk builds several corner cases by hand: a three-way split read whose last piece wraps the 7-bit address, and completions that break two or three rules at once. The wrapping read catches an address that saturates or carries, because the final completion of that read would then be misreported as 0101. The multi-fault completions catch a wrong check order, which shows up as the code of a later check. Directed tests reissue a busy tag, where a design without the busy guard overwrites the entry and fails the following byte-count check. They also let a timer expire, which shows an early or missing timeout and stray descriptor bits. Finally, a function-level reset hits two of three entries; a design that purges the wrong set or drains in the wrong order shows a wrong tag sequence or a surviving entry.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int RID_W  = 16;
    localparam int TC_W   = 3;
    localparam int ATTR_W = 3;
    localparam int FN_W   = 8;
    localparam int BC_W   = 13;
    localparam int LA_W   = 7;
    localparam int ST_W   = 3;

    localparam int DW        = 96;
    localparam int D_CODE_LO = 12;
    localparam int D_DONE    = 30;
    localparam int D_FN_LO   = 48;
    localparam int D_TAG_LO  = 64;
    localparam int D_TAG_W   = 8;

    typedef enum logic [3:0] {
        EC_OK     = 4'b0000,
        EC_STATUS = 4'b0010,
        EC_BCNT   = 4'b0011,
        EC_MATCH  = 4'b0100,
        EC_ADDR   = 4'b0101,
        EC_NOTAG  = 4'b0110,
        EC_OVER   = 4'b0111,
        EC_TERM   = 4'b1000
    } ecode_t;

    typedef struct packed {
        logic [RID_W-1:0]  rid;
        logic [TC_W-1:0]   tc;
        logic [ATTR_W-1:0] attr;
        logic [FN_W-1:0]   fn;
        logic [BC_W-1:0]   total;
        logic [BC_W-1:0]   remain;
        logic [LA_W-1:0]   la;
    } ent_t;
endpackage

// File: rtl/cst_entry.sv
module cst_entry
    import cst_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  ent_t             alloc_ent,
    input  logic [TMR_W-1:0] tmo_val,
    input  logic             upd,
    input  logic [BC_W-1:0]  upd_remain,
    input  logic [LA_W-1:0]  upd_la,
    input  logic             free,
    input  logic             flr_valid,
    input  logic [FN_W-1:0]  flr_fn,
    output logic             busy_o,
    output logic             live_o,
    output logic             term_o,
    output ent_t             ent_o
);
    logic             valid;
    logic             term;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            term  <= 1'b0;
            tmr   <= '0;
            ent_o <= '0;
        end else if (alloc) begin
            valid <= 1'b1;
            term  <= 1'b0;
            tmr   <= tmo_val;
            ent_o <= alloc_ent;
        end else if (free) begin
            valid <= 1'b0;
            term  <= 1'b0;
        end else if (valid) begin
            if (upd) begin
                ent_o.remain <= upd_remain;
                ent_o.la     <= upd_la;
            end
            if (!term) begin
                if ((flr_valid && flr_fn == ent_o.fn) || tmr <= TMR_W'(1)) begin
                    term <= 1'b1;
                end
                if (tmr != '0) begin
                    tmr <= tmr - TMR_W'(1);
                end
            end
        end
    end

    assign busy_o = valid;
    assign live_o = valid && !term;
    assign term_o = valid && term;
endmodule

// File: rtl/cst_classify.sv
module cst_classify
    import cst_pkg::*;
(
    input  logic              hit,
    input  ent_t              ent,
    input  logic [RID_W-1:0]  cpl_rid,
    input  logic [TC_W-1:0]   cpl_tc,
    input  logic [ATTR_W-1:0] cpl_attr,
    input  logic [ST_W-1:0]   cpl_status,
    input  logic [BC_W-1:0]   cpl_bytes,
    input  logic [BC_W-1:0]   cpl_len,
    input  logic [LA_W-1:0]   cpl_la,
    output ecode_t            code,
    output logic              done,
    output logic              upd,
    output logic              free,
    output logic [BC_W-1:0]   n_remain,
    output logic [LA_W-1:0]   n_la
);
    logic last;

    always_comb begin
        last     = cpl_len >= ent.remain;
        n_remain = last ? '0 : ent.remain - cpl_len;
        n_la     = ent.la + cpl_len[LA_W-1:0];
        code     = EC_OK;
        done     = 1'b0;
        upd      = 1'b0;
        free     = 1'b0;
        if (!hit) begin
            code = EC_NOTAG;
        end else if (cpl_rid != ent.rid || cpl_tc != ent.tc || cpl_attr != ent.attr) begin
            code = EC_MATCH;
        end else if (cpl_status != '0) begin
            code = EC_STATUS;
            done = 1'b1;
            free = 1'b1;
        end else if (cpl_bytes > ent.total) begin
            code = EC_OVER;
            done = 1'b1;
            free = 1'b1;
        end else if (cpl_bytes != ent.remain) begin
            code = EC_BCNT;
            done = 1'b1;
            free = 1'b1;
        end else begin
            code = (cpl_la != ent.la) ? EC_ADDR : EC_OK;
            done = last;
            free = last;
            upd  = !last;
        end
    end
endmodule

// File: rtl/cst_pick.sv
module cst_pick #(
    parameter int NTAG  = 32,
    parameter int TAG_W = $clog2(NTAG)
) (
    input  logic [NTAG-1:0]  term,
    output logic             any,
    output logic [TAG_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (term[i]) begin
                any = 1'b1;
                idx = TAG_W'(i);
            end
        end
    end
endmodule

// File: rtl/cpl_split_tracker.sv
module cpl_split_tracker
    import cst_pkg::*;
#(
    parameter  int NTAG  = 32,
    parameter  int TMR_W = 16,
    localparam int TAG_W = $clog2(NTAG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  tmo_val,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [TC_W-1:0]   req_tc,
    input  logic [ATTR_W-1:0] req_attr,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic [LA_W-1:0]   req_la,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [RID_W-1:0]  cpl_rid,
    input  logic [TC_W-1:0]   cpl_tc,
    input  logic [ATTR_W-1:0] cpl_attr,
    input  logic [ST_W-1:0]   cpl_status,
    input  logic [BC_W-1:0]   cpl_bytes,
    input  logic [BC_W-1:0]   cpl_len,
    input  logic [LA_W-1:0]   cpl_la,
    input  logic              flr_valid,
    input  logic [FN_W-1:0]   flr_fn,
    output logic [NTAG-1:0]   tag_busy,
    output logic              dsc_valid,
    output logic [DW-1:0]     dsc_word
);
    typedef enum logic {ST_IDLE, ST_DRAIN} state_t;

    state_t          st, st_nx;
    ent_t            ents [NTAG];
    logic [NTAG-1:0] busy_v, live_v, term_v;
    ent_t            alloc_ent;
    ecode_t          cls_code;
    logic            cls_done, cls_upd, cls_free;
    logic [BC_W-1:0] cls_remain;
    logic [LA_W-1:0] cls_la;
    logic            pick_any, emit;
    logic [TAG_W-1:0] pick_idx;
    logic [DW-1:0]   nx_word;

    assign alloc_ent = '{rid: req_rid, tc: req_tc, attr: req_attr, fn: req_fn,
                         total: req_bytes, remain: req_bytes, la: req_la};

    for (genvar g = 0; g < NTAG; g++) begin : g_ent
        localparam logic [TAG_W-1:0] IDX = TAG_W'(g);
        logic sel_cpl;
        assign sel_cpl = cpl_valid && cpl_tag == IDX;
        cst_entry #(.TMR_W(TMR_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (req_valid && req_tag == IDX && !busy_v[g]),
            .alloc_ent  (alloc_ent),
            .tmo_val    (tmo_val),
            .upd        (sel_cpl && cls_upd),
            .upd_remain (cls_remain),
            .upd_la     (cls_la),
            .free       ((sel_cpl && cls_free) || (emit && pick_idx == IDX)),
            .flr_valid  (flr_valid),
            .flr_fn     (flr_fn),
            .busy_o     (busy_v[g]),
            .live_o     (live_v[g]),
            .term_o     (term_v[g]),
            .ent_o      (ents[g])
        );
    end

    cst_classify u_cls (
        .hit        (live_v[cpl_tag]),
        .ent        (ents[cpl_tag]),
        .cpl_rid    (cpl_rid),
        .cpl_tc     (cpl_tc),
        .cpl_attr   (cpl_attr),
        .cpl_status (cpl_status),
        .cpl_bytes  (cpl_bytes),
        .cpl_len    (cpl_len),
        .cpl_la     (cpl_la),
        .code       (cls_code),
        .done       (cls_done),
        .upd        (cls_upd),
        .free       (cls_free),
        .n_remain   (cls_remain),
        .n_la       (cls_la)
    );

    cst_pick #(.NTAG(NTAG), .TAG_W(TAG_W)) u_pick (
        .term (term_v),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (|term_v)    st_nx = ST_DRAIN;
            ST_DRAIN: if (!(|term_v)) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Completions always win the output slot over synthetic descriptors
    assign emit = (st == ST_DRAIN) && !cpl_valid && pick_any;

    always_comb begin
        nx_word = '0;
        if (cpl_valid) begin
            nx_word[D_CODE_LO +: 4]      = cls_code;
            nx_word[D_DONE]              = cls_done;
            nx_word[D_FN_LO +: FN_W]     = live_v[cpl_tag] ? ents[cpl_tag].fn : '0;
            nx_word[D_TAG_LO +: D_TAG_W] = D_TAG_W'(cpl_tag);
        end else if (emit) begin
            nx_word[D_CODE_LO +: 4]      = EC_TERM;
            nx_word[D_DONE]              = 1'b1;
            nx_word[D_FN_LO +: FN_W]     = ents[pick_idx].fn;
            nx_word[D_TAG_LO +: D_TAG_W] = D_TAG_W'(pick_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_valid <= 1'b0;
            dsc_word  <= '0;
        end else begin
            dsc_valid <= cpl_valid || emit;
            dsc_word  <= nx_word;
        end
    end

    assign tag_busy = busy_v;
endmodule

// File: rtl/cpl_split_tracker_chk.sv
module cpl_split_tracker_chk
    import cst_pkg::*;
#(
    parameter int NTAG = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpl_valid,
    input logic [NTAG-1:0] tag_busy,
    input logic            dsc_valid,
    input logic [DW-1:0]   dsc_word
);
    logic [3:0] code;
    logic       done;
    logic [DW-1:0] keep;

    assign code = dsc_word[D_CODE_LO +: 4];
    assign done = dsc_word[D_DONE];

    always_comb begin
        keep = '0;
        keep[D_CODE_LO +: 4]      = '1;
        keep[D_DONE]              = 1'b1;
        keep[D_FN_LO +: FN_W]     = '1;
        keep[D_TAG_LO +: D_TAG_W] = '1;
    end

    // R12
    a_r12_one_per_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> dsc_valid);

    // R8
    a_r8_notag_open: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && code == EC_NOTAG) |-> !done);

    // R6
    a_r6_mismatch_open: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && code == EC_MATCH) |-> !done);

    // R4, R5, R10
    a_r4_terminal_done: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && (code == EC_STATUS || code == EC_BCNT ||
                       code == EC_OVER || code == EC_TERM)) |-> done);

    // R10
    a_r10_synth_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && code == EC_TERM) |-> ((dsc_word & ~keep) == '0));

    // R2: a tag is only released alongside a done descriptor
    a_r2_free_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tag_busy) < $past($countones(tag_busy))) |-> (dsc_valid && done));
endmodule

bind cpl_split_tracker cpl_split_tracker_chk #(.NTAG(NTAG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_valid (cpl_valid),
    .tag_busy  (tag_busy),
    .dsc_valid (dsc_valid),
    .dsc_word  (dsc_word)
);

// File: tb/tb_cpl_split_tracker.sv
`timescale 1ns/1ps
module tb_cpl_split_tracker;
    localparam int NTAG  = 32;
    localparam int TMR_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmo_val = 16'd2000;
    logic        req_valid = 1'b0;
    logic [4:0]  req_tag = '0;
    logic [15:0] req_rid = '0;
    logic [2:0]  req_tc = '0, req_attr = '0;
    logic [7:0]  req_fn = '0;
    logic [12:0] req_bytes = '0;
    logic [6:0]  req_la = '0;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_tag = '0;
    logic [15:0] cpl_rid = '0;
    logic [2:0]  cpl_tc = '0, cpl_attr = '0, cpl_status = '0;
    logic [12:0] cpl_bytes = '0, cpl_len = '0;
    logic [6:0]  cpl_la = '0;
    logic        flr_valid = 1'b0;
    logic [7:0]  flr_fn = '0;
    logic [NTAG-1:0] tag_busy;
    logic        dsc_valid;
    logic [95:0] dsc_word;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cpl_split_tracker #(.NTAG(NTAG), .TMR_W(TMR_W)) dut (
        .clk(clk), .rst_n(rst_n), .tmo_val(tmo_val),
        .req_valid(req_valid), .req_tag(req_tag), .req_rid(req_rid), .req_tc(req_tc),
        .req_attr(req_attr), .req_fn(req_fn), .req_bytes(req_bytes), .req_la(req_la),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_rid(cpl_rid), .cpl_tc(cpl_tc),
        .cpl_attr(cpl_attr), .cpl_status(cpl_status), .cpl_bytes(cpl_bytes),
        .cpl_len(cpl_len), .cpl_la(cpl_la), .flr_valid(flr_valid), .flr_fn(flr_fn),
        .tag_busy(tag_busy), .dsc_valid(dsc_valid), .dsc_word(dsc_word)
    );

    typedef struct packed {
        logic        is_cpl;
        logic [4:0]  tag;
        logic [15:0] rid;
        logic [2:0]  tc;
        logic [2:0]  attr;
        logic [7:0]  fn;
        logic [2:0]  st;
        logic [12:0] bc;
        logic [12:0] len;
        logic [6:0]  la;
        logic [3:0]  code;
        logic        done;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd3,  16'h0100, 3'd0, 3'd0, 8'h01, 3'd0, 13'd256, 13'd0,   7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd3,  16'h0100, 3'd0, 3'd0, 8'h00, 3'd0, 13'd256, 13'd64,  7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd3,  16'h0100, 3'd0, 3'd0, 8'h00, 3'd0, 13'd192, 13'd64,  7'h40, 4'h0, 1'b0},
        '{1'b1, 5'd3,  16'h0100, 3'd0, 3'd0, 8'h00, 3'd0, 13'd128, 13'd128, 7'h00, 4'h0, 1'b1},
        '{1'b1, 5'd3,  16'h0100, 3'd0, 3'd0, 8'h00, 3'd0, 13'd128, 13'd128, 7'h00, 4'h6, 1'b0},
        '{1'b0, 5'd7,  16'h0200, 3'd2, 3'd1, 8'h02, 3'd0, 13'd100, 13'd0,   7'h10, 4'h0, 1'b0},
        '{1'b1, 5'd7,  16'h0201, 3'd2, 3'd1, 8'h00, 3'd0, 13'd100, 13'd100, 7'h10, 4'h4, 1'b0},
        '{1'b1, 5'd7,  16'h0200, 3'd3, 3'd1, 8'h00, 3'd0, 13'd100, 13'd100, 7'h10, 4'h4, 1'b0},
        '{1'b1, 5'd7,  16'h0200, 3'd2, 3'd0, 8'h00, 3'd0, 13'd100, 13'd100, 7'h10, 4'h4, 1'b0},
        '{1'b1, 5'd7,  16'h0200, 3'd2, 3'd1, 8'h00, 3'd1, 13'd100, 13'd100, 7'h10, 4'h2, 1'b1},
        '{1'b1, 5'd7,  16'h0200, 3'd2, 3'd1, 8'h00, 3'd0, 13'd100, 13'd100, 7'h10, 4'h6, 1'b0},
        '{1'b0, 5'd9,  16'h0300, 3'd0, 3'd2, 8'h03, 3'd0, 13'd64,  13'd0,   7'h20, 4'h0, 1'b0},
        '{1'b1, 5'd9,  16'h0300, 3'd0, 3'd2, 8'h00, 3'd0, 13'd80,  13'd64,  7'h20, 4'h7, 1'b1},
        '{1'b0, 5'd10, 16'h0300, 3'd0, 3'd0, 8'h03, 3'd0, 13'd64,  13'd0,   7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd10, 16'h0300, 3'd0, 3'd0, 8'h00, 3'd0, 13'd60,  13'd60,  7'h00, 4'h3, 1'b1},
        '{1'b0, 5'd11, 16'h0400, 3'd0, 3'd0, 8'h04, 3'd0, 13'd128, 13'd0,   7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd11, 16'h0400, 3'd0, 3'd0, 8'h00, 3'd0, 13'd128, 13'd64,  7'h08, 4'h5, 1'b0},
        '{1'b1, 5'd11, 16'h0400, 3'd0, 3'd0, 8'h00, 3'd0, 13'd64,  13'd64,  7'h40, 4'h0, 1'b1},
        '{1'b0, 5'd12, 16'h0500, 3'd0, 3'd0, 8'h05, 3'd0, 13'd32,  13'd0,   7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd12, 16'h0501, 3'd0, 3'd0, 8'h00, 3'd4, 13'd16,  13'd16,  7'h00, 4'h4, 1'b0},
        '{1'b1, 5'd12, 16'h0500, 3'd0, 3'd0, 8'h00, 3'd4, 13'd16,  13'd16,  7'h00, 4'h2, 1'b1},
        '{1'b0, 5'd13, 16'h0600, 3'd0, 3'd0, 8'h06, 3'd0, 13'd32,  13'd0,   7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd13, 16'h0600, 3'd0, 3'd0, 8'h00, 3'd0, 13'd40,  13'd32,  7'h11, 4'h7, 1'b1},
        '{1'b0, 5'd14, 16'h0700, 3'd0, 3'd0, 8'h07, 3'd0, 13'd64,  13'd0,   7'h70, 4'h0, 1'b0},
        '{1'b1, 5'd14, 16'h0700, 3'd0, 3'd0, 8'h00, 3'd0, 13'd64,  13'd32,  7'h70, 4'h0, 1'b0},
        '{1'b1, 5'd14, 16'h0700, 3'd0, 3'd0, 8'h00, 3'd0, 13'd32,  13'd32,  7'h10, 4'h0, 1'b1},
        '{1'b1, 5'd15, 16'h0700, 3'd0, 3'd0, 8'h00, 3'd0, 13'd32,  13'd32,  7'h10, 4'h6, 1'b0},
        '{1'b0, 5'd16, 16'h0800, 3'd0, 3'd0, 8'h08, 3'd0, 13'd48,  13'd0,   7'h00, 4'h0, 1'b0},
        '{1'b1, 5'd16, 16'h0800, 3'd0, 3'd0, 8'h00, 3'd0, 13'd47,  13'd47,  7'h05, 4'h3, 1'b1}
    };

    function automatic string req_of(int i, logic [3:0] c);
        if (i == 19 || i == 20 || i == 22 || i == 28) return "R9";
        case (c)
            4'h0: return "R3";
            4'h2: return "R4";
            4'h3, 4'h7: return "R5";
            4'h4: return "R6";
            4'h5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_req(input logic [4:0] t, input logic [15:0] rid, input logic [2:0] tc,
                          input logic [2:0] at, input logic [7:0] fn, input logic [12:0] bc,
                          input logic [6:0] la);
        req_valid = 1'b1; req_tag = t; req_rid = rid; req_tc = tc; req_attr = at;
        req_fn = fn; req_bytes = bc; req_la = la;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_cpl(input logic [4:0] t, input logic [15:0] rid, input logic [2:0] tc,
                          input logic [2:0] at, input logic [2:0] st, input logic [12:0] bc,
                          input logic [12:0] len, input logic [6:0] la);
        cpl_valid = 1'b1; cpl_tag = t; cpl_rid = rid; cpl_tc = tc; cpl_attr = at;
        cpl_status = st; cpl_bytes = bc; cpl_len = len; cpl_la = la;
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // {valid, code, done, tag} of the current descriptor
    function automatic logic [13:0] dsum();
        return {dsc_valid, dsc_word[15:12], dsc_word[30], dsc_word[71:64]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(!dsc_valid && tag_busy == '0, "R1", {dsc_valid, tag_busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dsc_valid && tag_busy == '0, "R1", {dsc_valid, tag_busy}, 0);

        for (int i = 0; i < NV; i++) begin
            if (!VEC[i].is_cpl) begin
                do_req(VEC[i].tag, VEC[i].rid, VEC[i].tc, VEC[i].attr, VEC[i].fn,
                       VEC[i].bc, VEC[i].la);
            end else begin
                logic [13:0] exp_s;
                do_cpl(VEC[i].tag, VEC[i].rid, VEC[i].tc, VEC[i].attr, VEC[i].st,
                       VEC[i].bc, VEC[i].len, VEC[i].la);
                exp_s = {1'b1, VEC[i].code, VEC[i].done, 3'b000, VEC[i].tag};
                chk(dsum() == exp_s, req_of(i, VEC[i].code), dsum(), exp_s);
            end
        end
        // R3 R4 R5: all table tags released
        chk(tag_busy == '0, "R3", tag_busy, 0);

        // R2: busy tag, second request ignored
        do_req(5'd5, 16'h0A00, 3'd0, 3'd0, 8'h0A, 13'd32, 7'h00);
        chk(tag_busy[5], "R2", tag_busy, 32'h20);
        do_req(5'd5, 16'h0B00, 3'd0, 3'd0, 8'h0B, 13'd64, 7'h00);
        do_cpl(5'd5, 16'h0A00, 3'd0, 3'd0, 3'd0, 13'd32, 13'd32, 7'h00);
        chk(dsum() == {1'b1, 4'h0, 1'b1, 8'd5}, "R2", dsum(), {1'b1, 4'h0, 1'b1, 8'd5});
        chk(dsc_word[55:48] == 8'h0A, "R2", dsc_word[55:48], 8'h0A);

        // R10: timeout
        tmo_val = 16'd20;
        do_req(5'd20, 16'h0C00, 3'd1, 3'd1, 8'h07, 13'd64, 7'h00);
        begin
            int n;
            logic [95:0] exp_w;
            n = 0;
            while (!dsc_valid && n < 200) begin
                @(negedge clk);
                n++;
                if (n == 10) chk(tag_busy[20], "R10", tag_busy, 32'h100000);
            end
            exp_w = '0;
            exp_w[15:12] = 4'h8; exp_w[30] = 1'b1; exp_w[55:48] = 8'h07; exp_w[71:64] = 8'd20;
            chk(n >= 20 && n <= 23, "R10", n, 20);
            chk(dsc_word == exp_w, "R10", dsc_word[71:0], exp_w[71:0]);
            @(negedge clk);
            chk(!tag_busy[20] && !dsc_valid, "R10", {dsc_valid, tag_busy[20]}, 0);
        end
        tmo_val = 16'd2000;

        // R11: FLR of function 5 hits tags 1 and 2 only
        do_req(5'd2, 16'h0D00, 3'd0, 3'd0, 8'h05, 13'd16, 7'h00);
        do_req(5'd1, 16'h0D00, 3'd0, 3'd0, 8'h05, 13'd16, 7'h00);
        do_req(5'd4, 16'h0E00, 3'd0, 3'd0, 8'h06, 13'd16, 7'h00);
        flr_valid = 1'b1; flr_fn = 8'h05;
        @(posedge clk);
        @(negedge clk);
        flr_valid = 1'b0;
        begin
            int seen;
            logic [15:0] tags;
            seen = 0;
            tags = '0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (dsc_valid) begin
                    if (seen < 2) tags[seen*8 +: 8] = dsc_word[71:64];
                    chk(dsc_word[15:12] == 4'h8 && dsc_word[30] && dsc_word[55:48] == 8'h05,
                        "R11", dsc_word[71:0], 0);
                    seen++;
                end
            end
            chk(seen == 2, "R11", seen, 2);
            chk(tags == 16'h0201, "R11", tags, 16'h0201);
            chk(tag_busy[4] && !tag_busy[1] && !tag_busy[2], "R11", tag_busy, 32'h10);
        end
        do_cpl(5'd1, 16'h0D00, 3'd0, 3'd0, 3'd0, 13'd16, 13'd16, 7'h00);
        chk(dsum() == {1'b1, 4'h6, 1'b0, 8'd1}, "R11", dsum(), {1'b1, 4'h6, 1'b0, 8'd1});
        do_cpl(5'd4, 16'h0E00, 3'd0, 3'd0, 3'd0, 13'd16, 13'd16, 7'h00);
        chk(dsum() == {1'b1, 4'h0, 1'b1, 8'd4}, "R11", dsum(), {1'b1, 4'h0, 1'b1, 8'd4});

        // R12: no completion, no pending termination -> no descriptor
        @(negedge clk);
        chk(!dsc_valid && dsc_word == '0, "R12", dsc_valid, 0);

        finished = 1;
        finish_run();
    end
endmodule